// File: doc/BRIEF.md
# Keyed 32-bit Byte Permutation

This block scrambles a 32-bit word under a 64-bit key with one round of a small substitution/permutation network. It serves as a cheap randomising step for deriving a table index and tag from a key such as an address. It is not built for secrecy. Because the function is a bijection for any fixed key, the bits that are not used as the index can serve as the tag with no loss of information.

The round runs in four steps. Each byte goes through a pair of 4-bit substitution boxes. Each byte is then rotated and added to a key byte. Next comes a key-dependent XOR mix whose later bytes feed on earlier results. A second substitution layer follows, and the round ends with a key-free XOR/rotate mix with feedback, which makes the upper output bytes depend on every input and key bit. A word and its key are captured together on a strobe. The result appears on the output register one clock later, alongside a valid flag.

Top module: `keyperm_core`

## Requirements
- R1: While reset is active, and after it, until the first result, `out_valid` is 0 and `out_data` is 0.
- R2: The first substitution maps the upper nibble of each input byte through box P0 = {3,8,F,1,A,6,5,B,E,D,4,2,7,0,9,C} and the lower nibble through box P1 = {F,C,2,7,9,0,5,A,1,B,E,8,6,D,3,4}. Both boxes are listed as hex outputs for inputs 0..F. Byte i (bits 8i+7:8i, i=0..3) is then rotated right by i+2 bits and added mod 256 to key bits 8i+7:8i, giving b_i.
- R3: The key mix forms c0 = b0^rotr(b1,1)^rotr(b2,2)^k4, c1 = b1^rotr(b2,4)^rotr(b3,5)^k5, c2 = b2^rotr(b3,7)^rotr(c0,1)^k6 and c3 = b3^rotr(c0,3)^rotr(c1,4)^k7, where k_j is key bits 8j+7:8j.
- R4: The second substitution maps the upper nibble of each c byte through P2 = {8,6,7,9,3,C,A,F,D,1,E,4,0,B,5,2} and the lower nibble through P3 = {0,F,B,8,C,9,6,3,D,1,2,4,A,7,5,E}, giving d_i.
- R5: The final mix forms e0 = d0^rotr(d1,1)^rotr(d2,5)^rotr(d3,2), e1 = d1^rotr(d2,2)^rotr(d3,6)^rotr(e0,3), e2 = d2^rotr(d3,3)^rotr(e0,7)^rotr(e1,4) and e3 = d3^rotr(e0,4)^rotr(e1,1)^rotr(e2,5). The output is out_data = {e3,e2,e1,e0}, with e0 in bits 7:0.
- R6: A word presented with `in_valid` high at rising edge n appears on `out_data` with `out_valid` high after rising edge n+1.
- R7: The key is sampled at the same edge as the data. A change of `in_key` after that edge does not alter the pending result.
- R8: Words presented on consecutive cycles produce results on consecutive cycles, in the order they were presented.
- R9: In a cycle that follows an edge without `in_valid`, `out_valid` is 0 and `out_data` keeps its previous value, whatever `in_data` and `in_key` carry.
- R10: For a fixed key, distinct input words give distinct output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: capture `in_data` and `in_key` at this edge |
| in_data | input | 32 | Word to permute |
| in_key | input | 64 | Permutation key |
| out_valid | output | 1 | `out_data` holds a new result this cycle |
| out_data | output | 32 | Permuted word |

## Verification
Two things can happen in the same cycle: a new word is captured into the input register while the previous word's result is loaded into the output register. The bench provokes this with a burst of strobes on every cycle, each carrying a different key. Every result is judged against a behavioural model and against the cycle in which it is due. A slip in either register would show up as a wrong value, a wrong key pairing or a wrong arrival cycle for some item in the burst.

// File: rtl/keyperm_pkg.sv
package keyperm_pkg;

   localparam int unsigned BYTE_BITS = 8;

   // substitution tables, entry n in bits 4n+3:4n
   localparam logic [63:0] BOX_P0 = 64'hC907_24DE_B56A_1F83;
   localparam logic [63:0] BOX_P1 = 64'h43D6_8EB1_A509_72CF;
   localparam logic [63:0] BOX_P2 = 64'h25B0_4E1D_FAC3_9768;
   localparam logic [63:0] BOX_P3 = 64'hE57A_421D_369C_8BF0;

   typedef logic [BYTE_BITS-1:0] kp_byte_t;

   function automatic logic [3:0] box_lookup(input logic [63:0] tbl, input logic [3:0] nib);
      return tbl[nib*4 +: 4];
   endfunction

   function automatic kp_byte_t rotr8(input kp_byte_t x, input int unsigned n);
      kp_byte_t r;
      r = kp_byte_t'((x >> n) | (x << (BYTE_BITS - n)));
      return r;
   endfunction

endpackage

// File: rtl/kp_sbox_layer.sv
module kp_sbox_layer
   import keyperm_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = 8,
   parameter bit          SECOND = 1'b0
) (
   input  logic [LANES-1:0][BYTE_W-1:0] lane_in,
   output logic [LANES-1:0][BYTE_W-1:0] lane_out
);
   localparam logic [63:0] HI_TBL = SECOND ? BOX_P2 : BOX_P0;
   localparam logic [63:0] LO_TBL = SECOND ? BOX_P3 : BOX_P1;

   if (BYTE_W != 8) begin : g_bad_width
      $error("kp_sbox_layer: BYTE_W must be 8");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
         lane_out[i][7:4] = box_lookup(HI_TBL, lane_in[i][7:4]);
         lane_out[i][3:0] = box_lookup(LO_TBL, lane_in[i][3:0]);
      end
   end
endmodule

// File: rtl/kp_key_mix.sv
module kp_key_mix
   import keyperm_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [LANES-1:0][BYTE_W-1:0]   sub_in,
   input  logic [2*LANES-1:0][BYTE_W-1:0] key,
   output logic [LANES-1:0][BYTE_W-1:0]   mix_out
);
   logic [LANES-1:0][BYTE_W-1:0] b;

   if (LANES != 4) begin : g_bad_lanes
      $error("kp_key_mix: schedule is defined for four lanes");
   end

   // rotate by lane+2 and add the low key bytes
   for (genvar i = 0; i < LANES; i++) begin : g_add
      assign b[i] = rotr8(sub_in[i], i + 2) + key[i];
   end

   always_comb begin
      mix_out[0] = b[0] ^ rotr8(b[1], 1) ^ rotr8(b[2], 2) ^ key[4];
      mix_out[1] = b[1] ^ rotr8(b[2], 4) ^ rotr8(b[3], 5) ^ key[5];
      mix_out[2] = b[2] ^ rotr8(b[3], 7) ^ rotr8(mix_out[0], 1) ^ key[6];
      mix_out[3] = b[3] ^ rotr8(mix_out[0], 3) ^ rotr8(mix_out[1], 4) ^ key[7];
   end
endmodule

// File: rtl/kp_diffuse.sv
module kp_diffuse
   import keyperm_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [LANES-1:0][BYTE_W-1:0] d,
   output logic [LANES-1:0][BYTE_W-1:0] e
);
   if (LANES != 4) begin : g_bad_lanes
      $error("kp_diffuse: schedule is defined for four lanes");
   end

   always_comb begin
      e[0] = d[0] ^ rotr8(d[1], 1) ^ rotr8(d[2], 5) ^ rotr8(d[3], 2);
      e[1] = d[1] ^ rotr8(d[2], 2) ^ rotr8(d[3], 6) ^ rotr8(e[0], 3);
      e[2] = d[2] ^ rotr8(d[3], 3) ^ rotr8(e[0], 7) ^ rotr8(e[1], 4);
      e[3] = d[3] ^ rotr8(e[0], 4) ^ rotr8(e[1], 1) ^ rotr8(e[2], 5);
   end
endmodule

// File: rtl/keyperm_core.sv
module keyperm_core #(
   parameter int unsigned LANES      = 4,
   parameter int unsigned BYTE_W     = 8,
   parameter bit          DATA_RESET = 1'b1,
   localparam int unsigned WORD_W    = LANES * BYTE_W,
   localparam int unsigned KEY_W     = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   input  logic [KEY_W-1:0]  in_key,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data
);
   if (LANES != 4 || BYTE_W != 8) begin : g_bad_cfg
      $error("keyperm_core: only a 4x8 word is supported");
   end

   logic                          stg_valid;
   logic [LANES-1:0][BYTE_W-1:0]  stg_data;
   logic [2*LANES-1:0][BYTE_W-1:0] stg_key;
   logic [LANES-1:0][BYTE_W-1:0]  sub_a, mix_c, sub_d, mix_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_valid <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         stg_valid <= in_valid;
         out_valid <= stg_valid;
      end
   end

   if (DATA_RESET) begin : g_data_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_data <= '0;
            stg_key  <= '0;
            out_data <= '0;
         end else begin
            if (in_valid) begin
               stg_data <= in_data;
               stg_key  <= in_key;
            end
            if (stg_valid) out_data <= mix_e;
         end
      end
   end else begin : g_data_norst
      always_ff @(posedge clk) begin
         if (in_valid) begin
            stg_data <= in_data;
            stg_key  <= in_key;
         end
         if (stg_valid) out_data <= mix_e;
      end
   end

   kp_sbox_layer #(.LANES(LANES), .BYTE_W(BYTE_W), .SECOND(1'b0)) u_sub_a (
      .lane_in (stg_data),
      .lane_out(sub_a)
   );

   kp_key_mix #(.LANES(LANES), .BYTE_W(BYTE_W)) u_key_mix (
      .sub_in (sub_a),
      .key    (stg_key),
      .mix_out(mix_c)
   );

   kp_sbox_layer #(.LANES(LANES), .BYTE_W(BYTE_W), .SECOND(1'b1)) u_sub_d (
      .lane_in (mix_c),
      .lane_out(sub_d)
   );

   kp_diffuse #(.LANES(LANES), .BYTE_W(BYTE_W)) u_diffuse (
      .d(sub_d),
      .e(mix_e)
   );

   // R6
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> stg_valid);

   // R6
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_valid |=> out_valid);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_valid |=> (!out_valid && $stable(out_data)));

   // R7
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(stg_key));

   // R1
   always_comb begin
      if (!rst_n) begin
         reset_state_chk: assert (out_valid == 1'b0);
      end
   end
endmodule

// File: tb/keyperm_core_tb_top.sv
module keyperm_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic [63:0] in_key = '0;
   logic        out_valid;
   logic [31:0] out_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q[$];
   int          due_q[$];
   logic [31:0] last_out = '0;
   bit          bij_on = 1'b0;
   int          bij_n = 0;
   logic [31:0] bij_buf[256];

   int p0[16] = '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12};
   int p1[16] = '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4};
   int p2[16] = '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2};
   int p3[16] = '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14};

   keyperm_core dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_key(in_key), .out_valid(out_valid), .out_data(out_data)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] rr(input logic [7:0] x, input int n);
      logic [15:0] w;
      w = {x, x} >> n;
      return w[7:0];
   endfunction

   function automatic logic [31:0] model(input logic [31:0] w, input logic [63:0] k);
      logic [7:0] a[4], b[4], c[4], d[4], e[4];
      for (int i = 0; i < 4; i++) begin
         a[i][7:4] = 4'(p0[w[8*i+4 +: 4]]);
         a[i][3:0] = 4'(p1[w[8*i +: 4]]);
         b[i] = rr(a[i], i + 2) + k[8*i +: 8];
      end
      c[0] = b[0] ^ rr(b[1], 1) ^ rr(b[2], 2) ^ k[39:32];
      c[1] = b[1] ^ rr(b[2], 4) ^ rr(b[3], 5) ^ k[47:40];
      c[2] = b[2] ^ rr(b[3], 7) ^ rr(c[0], 1) ^ k[55:48];
      c[3] = b[3] ^ rr(c[0], 3) ^ rr(c[1], 4) ^ k[63:56];
      for (int i = 0; i < 4; i++) begin
         d[i][7:4] = 4'(p2[c[i][7:4]]);
         d[i][3:0] = 4'(p3[c[i][3:0]]);
      end
      e[0] = d[0] ^ rr(d[1], 1) ^ rr(d[2], 5) ^ rr(d[3], 2);
      e[1] = d[1] ^ rr(d[2], 2) ^ rr(d[3], 6) ^ rr(e[0], 3);
      e[2] = d[2] ^ rr(d[3], 3) ^ rr(e[0], 7) ^ rr(e[1], 4);
      e[3] = d[3] ^ rr(e[0], 4) ^ rr(e[1], 1) ^ rr(e[2], 5);
      return {e[3], e[2], e[1], e[0]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic send(input logic [31:0] w, input logic [63:0] k);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      in_key   = k;
      exp_q.push_back(model(w, k));
      due_q.push_back(cyc + 2);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = $urandom;
         in_key   = {$urandom, $urandom};
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected result", {32'd0, out_data}, 64'd0);
            end else begin
               logic [31:0] ev;
               int dv;
               ev = exp_q.pop_front();
               dv = due_q.pop_front();
               check(out_data === ev, "R2/R3/R4/R5/R7/R8 value", {32'd0, out_data}, {32'd0, ev});
               check(cyc == dv, "R6 latency", 64'(cyc), 64'(dv));
            end
            if (bij_on && bij_n < 256) begin
               bij_buf[bij_n] = out_data;
               bij_n++;
            end
            last_out = out_data;
         end else begin
            check(out_data === last_out, "R9 hold", {32'd0, out_data}, {32'd0, last_out});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state, with the strobe driven
      in_valid = 1'b1;
      in_data  = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R1 valid in reset", {63'd0, out_valid}, 64'd0);
      check(out_data === 32'd0, "R1 data in reset", {32'd0, out_data}, 64'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      check(out_valid === 1'b0 && out_data === 32'd0, "R1 after reset",
            {31'd0, out_valid, out_data}, 64'd0);

      // R2 R3 R4 R5: directed corners
      send(32'h0000_0000, 64'd0);
      idle(3);
      send(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
      idle(3);
      send(32'h0123_4567, 64'h89AB_CDEF_0011_2233);
      idle(3);
      send(32'h8000_0001, 64'h0000_0001_8000_0000);
      idle(2);

      // R7: key and data change right after capture
      send(32'hDEAD_BEEF, 64'h0F1E_2D3C_4B5A_6978);
      idle(4);

      // R8: back-to-back burst with a new key each cycle
      for (int i = 0; i < 40; i++) send($urandom, {$urandom, $urandom});
      idle(4);

      // R9: long gap with noisy inputs
      idle(10);

      // random spaced traffic
      for (int i = 0; i < 60; i++) begin
         send($urandom, {$urandom, $urandom});
         idle(i % 3);
      end
      idle(4);

      // R10: distinct inputs under one key
      bij_on = 1'b1;
      for (int i = 0; i < 256; i++) send(32'(i) * 32'h0101_0001 ^ 32'(i << 20), 64'hA5A5_5A5A_3C3C_C3C3);
      idle(5);
      bij_on = 1'b0;
      begin
         int dup;
         dup = 0;
         for (int i = 0; i < 256; i++)
            for (int j = i + 1; j < 256; j++)
               if (bij_buf[i] === bij_buf[j]) dup++;
         check(bij_n == 256 && dup == 0, "R10 distinct outputs", 64'(dup), 64'd0);
      end

      check(exp_q.size() == 0, "R8 all results drained", 64'(exp_q.size()), 64'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule